// File: doc/BRIEF.md
# SPI master serial engine

This block is the serial core of an SPI master. Bytes queued in a small transmit FIFO are shifted out on MOSI one 8-bit frame at a time, most significant bit first. At the same time the byte arriving on MISO is assembled and stored in a receive FIFO. The serial clock runs at the peripheral clock divided by 2*(div+1). The clock polarity and phase come from a compile-time mode parameter, 0 to 3, and the default is mode 3.

A vector of select enables picks which of up to eight active-low slave selects are driven. In the default configuration a select is asserted while frames are in flight or queued, and it drops once the transmit FIFO has drained and the last frame has finished. With the hold parameter set, the selects follow the enable vector for as long as the engine is enabled. In that mode a frame that completes with nothing left to send raises an underrun pulse. A frame that completes while the receive FIFO is full raises an overflow pulse, and its byte is discarded.

Pulling the enable low stops the engine at once. SCLK returns to its idle level, all selects go high, and any partial frame is abandoned. The FIFOs keep their contents, and bytes may still be queued while the engine is disabled.

Top module: `spi_serial_master`

## Requirements
- R1: In mode 3, each frame shifts the transmit byte out on MOSI MSB first, and the 8 MISO bits, sampled on rising SCLK, are pushed into the RX FIFO as one byte with the first bit in bit 7.
- R2: A frame begins on the clock edge after the TX FIFO becomes non-empty while the engine is idle and enabled. Each SCLK half period lasts div+1 clocks. The frame ends after 16 half periods. A byte pushed into an idle block therefore produces its done pulse 2+16*(div+1) clocks after the cycle in which the push was driven.
- R3: A frame that ends while the RX FIFO is full pulses overflow in the same cycle as done. The byte is dropped, and the RX contents and order are unchanged.
- R4: A TX push while the TX FIFO is full is ignored. An RX pop while the RX FIFO is empty is ignored.
- R5: With HOLD_SS=0, ss_n[i] is low exactly when the engine is enabled, ss_en[i] is 1, and a frame is active or the TX FIFO is non-empty. It is high once the last queued frame has ended.
- R6: With HOLD_SS=1, ss_n[i] is low whenever the engine is enabled and ss_en[i] is 1, whatever the FIFO state.
- R7: underrun pulses with done only when HOLD_SS=1, the TX FIFO is empty and at least one ss_en bit is set. With HOLD_SS=0 it stays 0.
- R8: While en is 0, SCLK is at the CPOL level, all ss_n are 1 and busy is 0. A frame in progress is abandoned on the next edge, and it does not restart. TX pushes are still accepted, and queued bytes are sent once en returns to 1.
- R9: MODE bit 1 is CPOL, the idle SCLK level. MODE bit 0 is CPHA: with CPHA=0, MISO is sampled on leading edges and MOSI changes on trailing edges. Mode 0 transfers a byte correctly in both directions.
- R10: busy is high from the frame's load cycle through its last SCLK edge. done is a single-cycle pulse after each frame. A FIFO full flag and empty flag are never both high.
- R11: Queued bytes leave in push order, back to back. One idle clock separates consecutive frames, so successive done pulses are 17 clocks apart at div=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Engine enable |
| div | input | 8 | Clock divide value; SCLK = clk / (2*(div+1)) |
| tx_push | input | 1 | Write tx_data into the TX FIFO |
| tx_data | input | 8 | Byte to transmit |
| rx_pop | input | 1 | Remove the head of the RX FIFO |
| ss_en | input | NSS | Select enables, one per slave |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ss_n | output | NSS | Active-low slave selects |
| tx_full | output | 1 | TX FIFO full |
| tx_empty | output | 1 | TX FIFO empty |
| rx_full | output | 1 | RX FIFO full |
| rx_empty | output | 1 | RX FIFO empty |
| rx_data | output | 8 | Head of the RX FIFO |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse after each frame |
| overflow | output | 1 | Frame ended with the RX FIFO full |
| underrun | output | 1 | Frame ended with nothing left to send while selects are held |

## Verification
The properties take for granted that div is held steady while busy is high, because the half-period timing and the single-cycle done pulse rely on that. They also assume that MISO changes only on the SCLK edge opposite to the sampling edge. The stimulus changes div only between frames, while the engine is idle. The slave models move MISO only on falling SCLK, which is the non-sampling edge in both mode 3 and mode 0. A second instance, built with mode 0 and select hold, covers the parameter-dependent select and underrun behaviour.

// File: rtl/spi_serial_master.sv
module spi_serial_master #(
  parameter int DEPTH   = 4,
  parameter int MODE    = 3,
  parameter int HOLD_SS = 0,
  parameter int NSS     = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [7:0]     div,
  input  logic           tx_push,
  input  logic [7:0]     tx_data,
  input  logic           rx_pop,
  input  logic [NSS-1:0] ss_en,
  input  logic           miso,
  output logic           sclk,
  output logic           mosi,
  output logic [NSS-1:0] ss_n,
  output logic           tx_full,
  output logic           tx_empty,
  output logic           rx_full,
  output logic           rx_empty,
  output logic [7:0]     rx_data,
  output logic           busy,
  output logic           done,
  output logic           overflow,
  output logic           underrun
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam bit CPOL = ((MODE / 2) % 2) == 1;
  localparam bit CPHA = (MODE % 2) == 1;
  localparam bit HOLD = HOLD_SS != 0;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [7:0]    txm [DEPTH];
  logic [7:0]    rxm [DEPTH];
  logic [AW-1:0] twp, trp, rwp, rrp;
  logic [CW-1:0] tcnt, rcnt;

  logic       act, sclk_r;
  logic [7:0] pcnt, tsh, rsh;
  logic [3:0] ecnt;

  assign tx_full  = tcnt == CW'(DEPTH);
  assign tx_empty = tcnt == '0;
  assign rx_full  = rcnt == CW'(DEPTH);
  assign rx_empty = rcnt == '0;
  assign rx_data  = rxm[rrp];

  wire tx_wr = tx_push && !tx_full;
  wire rx_rd = rx_pop && !rx_empty;
  wire start = en && !act && !tx_empty;
  wire tick  = en && act && (pcnt == div);
  wire last  = tick && (ecnt == 4'd15);
  wire lead  = !ecnt[0];
  wire samp  = tick && (lead ^ CPHA);
  wire shft  = tick && !(lead ^ CPHA) && !last && !(CPHA && ecnt == 4'd0);
  wire rx_wr = last && !rx_full;
  wire [7:0] rbyte = CPHA ? {rsh[6:0], miso} : rsh;
  wire sel = en && (HOLD || act || !tx_empty);

  assign sclk = sclk_r;
  assign mosi = tsh[7];
  assign busy = act;
  assign ss_n = ~(ss_en & {NSS{sel}});

  always_ff @(posedge clk) begin
    if (tx_wr) txm[twp] <= tx_data;
    if (rx_wr) rxm[rwp] <= rbyte;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      twp  <= '0;
      trp  <= '0;
      tcnt <= '0;
      rwp  <= '0;
      rrp  <= '0;
      rcnt <= '0;
    end else begin
      if (tx_wr) twp <= inc(twp);
      if (start) trp <= inc(trp);
      tcnt <= tcnt + CW'(tx_wr) - CW'(start);
      if (rx_wr) rwp <= inc(rwp);
      if (rx_rd) rrp <= inc(rrp);
      rcnt <= rcnt + CW'(rx_wr) - CW'(rx_rd);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act      <= 1'b0;
      pcnt     <= '0;
      ecnt     <= '0;
      tsh      <= '0;
      rsh      <= '0;
      sclk_r   <= CPOL;
      done     <= 1'b0;
      overflow <= 1'b0;
      underrun <= 1'b0;
    end else begin
      done     <= last;
      overflow <= last && rx_full;
      underrun <= last && HOLD && tx_empty && (|ss_en);
      if (!en) begin
        act    <= 1'b0;
        pcnt   <= '0;
        ecnt   <= '0;
        tsh    <= '0;
        rsh    <= '0;
        sclk_r <= CPOL;
      end else if (start) begin
        act  <= 1'b1;
        pcnt <= '0;
        ecnt <= '0;
        tsh  <= txm[trp];
      end else if (act) begin
        if (tick) begin
          pcnt   <= '0;
          ecnt   <= ecnt + 4'd1;
          sclk_r <= ~sclk_r;
          if (last) act <= 1'b0;
        end else begin
          pcnt <= pcnt + 8'd1;
        end
        if (samp) rsh <= {rsh[6:0], miso};
        if (shft) tsh <= {tsh[6:0], 1'b0};
      end
    end
endmodule

module spi_serial_master_chk #(
  parameter int MODE = 3,
  parameter int NSS  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic           sclk,
  input logic [NSS-1:0] ss_n,
  input logic           busy,
  input logic           done,
  input logic           overflow,
  input logic           underrun,
  input logic           tx_full,
  input logic           tx_empty,
  input logic           rx_full,
  input logic           rx_empty
);
  localparam bit CPOL = ((MODE / 2) % 2) == 1;

  p_overflow_with_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> done);
  p_underrun_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> done);
  p_disabled_selects_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (&ss_n));
  p_idle_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == CPOL));
  p_done_follows_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_flags_sane_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_full && tx_empty) && !(rx_full && rx_empty));
endmodule

bind spi_serial_master spi_serial_master_chk #(.MODE(MODE), .NSS(NSS)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .sclk(sclk), .ss_n(ss_n), .busy(busy),
  .done(done), .overflow(overflow), .underrun(underrun), .tx_full(tx_full),
  .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty)
);

// File: tb/test_spi_serial_master.sv
module test_spi_serial_master;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0, en = 1'b0;
  logic [7:0] div = 8'd0, tx_data = 8'd0;
  logic       tx_push = 1'b0, rx_pop = 1'b0, miso = 1'b0;
  logic       tx_push_h = 1'b0, rx_pop_h = 1'b0, miso_h = 1'b0;
  logic [7:0] ss_en = 8'd0, ss_en_h = 8'd0;

  logic       sclk, mosi, tx_full, tx_empty, rx_full, rx_empty, busy, done, overflow, underrun;
  logic [7:0] ss_n, rx_data;
  logic       sclk_h, mosi_h, tx_full_h, tx_empty_h, rx_full_h, rx_empty_h, busy_h, done_h;
  logic       overflow_h, underrun_h;
  logic [7:0] ss_n_h, rx_data_h;

  spi_serial_master i_spi_serial_master (
    .clk(clk), .rst_n(rst_n), .en(en), .div(div), .tx_push(tx_push), .tx_data(tx_data),
    .rx_pop(rx_pop), .ss_en(ss_en), .miso(miso), .sclk(sclk), .mosi(mosi), .ss_n(ss_n),
    .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
    .rx_data(rx_data), .busy(busy), .done(done), .overflow(overflow), .underrun(underrun));

  spi_serial_master #(.MODE(0), .HOLD_SS(1)) i_spi_serial_master_hold (
    .clk(clk), .rst_n(rst_n), .en(en), .div(div), .tx_push(tx_push_h), .tx_data(tx_data),
    .rx_pop(rx_pop_h), .ss_en(ss_en_h), .miso(miso_h), .sclk(sclk_h), .mosi(mosi_h),
    .ss_n(ss_n_h), .tx_full(tx_full_h), .tx_empty(tx_empty_h), .rx_full(rx_full_h),
    .rx_empty(rx_empty_h), .rx_data(rx_data_h), .busy(busy_h), .done(done_h),
    .overflow(overflow_h), .underrun(underrun_h));

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave models: mode 3 for the default instance, mode 0 for the hold instance
  logic [7:0] s_tx = 8'd0, s_cap = 8'd0, h_tx = 8'd0, h_cap = 8'd0;
  int s_idx = -1, h_idx = -1;
  initial forever begin
    @(negedge sclk);
    if (s_idx >= 0) begin miso = s_tx[s_idx]; s_idx--; end
  end
  initial forever begin
    @(posedge sclk);
    s_cap = {s_cap[6:0], mosi};
  end
  initial forever begin
    @(negedge sclk_h);
    if (h_idx >= 0) begin miso_h = h_tx[h_idx]; h_idx--; end
  end
  initial forever begin
    @(posedge sclk_h);
    h_cap = {h_cap[6:0], mosi_h};
  end

  // tx[23:16] miso[15:8] div[7:0]
  localparam logic [23:0] VEC [6] = '{24'hA53C00, 24'h00FF01, 24'hFF0003,
                                      24'h817E00, 24'h5AC302, 24'h12ED07};

  logic [7:0] mid_ss;
  logic       mid_busy;

  task automatic send_one(input logic [7:0] tb, input logic [7:0] mb, output int n);
    s_tx = mb; s_idx = 7;
    tx_data = tb; tx_push = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      tx_push = 1'b0;
      if (n == 4) begin mid_ss = ss_n; mid_busy = busy; end
    end while (!done && n < 5000);
  endtask

  task automatic wait_done(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!done && n < 5000);
  endtask

  task automatic pop_rx;
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
  endtask

  initial begin
    int n;
    logic [7:0] exp_rx [4];
    repeat (3) @(negedge clk);
    chk("R8 reset sclk idle", sclk, 1);
    chk("R9 reset sclk_h idle", sclk_h, 0);
    chk("R8 reset ss_n", ss_n, 8'hFF);
    chk("R10 reset busy", busy, 0);
    chk("R10 reset done", done, 0);
    chk("R4 reset fifos empty", {tx_empty, rx_empty}, 2'b11);
    rst_n = 1'b1;
    @(negedge clk);
    en = 1'b1; ss_en = 8'h04;
    @(negedge clk);

    for (int k = 0; k < 6; k++) begin
      div = VEC[k][7:0];
      @(negedge clk);
      send_one(VEC[k][23:16], VEC[k][15:8], n);
      chk("R2 frame duration", n, 2 + 16 * (VEC[k][7:0] + 1));
      chk("R1 rx byte", rx_data, VEC[k][15:8]);
      chk("R1 mosi byte", s_cap, VEC[k][23:16]);
      chk("R5 select asserted in frame", mid_ss, 8'hFB);
      chk("R10 busy in frame", mid_busy, 1);
      chk("R5 select released after drain", ss_n, 8'hFF);
      chk("R7 no underrun without hold", underrun, 0);
      chk("R3 no overflow", overflow, 0);
      pop_rx;
      chk("R10 done single cycle", done, 0);
      chk("R10 rx empty after pop", rx_empty, 1);
    end

    // queue while disabled, overfill TX, then back-to-back frames
    div = 8'd0; en = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      tx_data = 8'(k * 8'h11); tx_push = 1'b1;
      @(negedge clk);
    end
    tx_push = 1'b0;
    chk("R4 tx full after overfill", tx_full, 1);
    chk("R8 selects high while disabled", ss_n, 8'hFF);
    chk("R8 idle while disabled", {busy, sclk}, 2'b01);
    s_tx = 8'hC1; s_idx = 7;
    en = 1'b1;
    wait_done(n);
    chk("R11 first queued byte", s_cap, 8'h11);
    for (int k = 2; k <= 4; k++) begin
      wait_done(n);
      chk("R11 back-to-back spacing", n, 17);
      chk("R11 push order", s_cap, 8'(k * 8'h11));
    end
    chk("R4 fifth push dropped", tx_empty, 1);
    chk("R3 rx full", rx_full, 1);
    repeat (40) @(negedge clk);
    chk("R4 no fifth frame", busy, 0);

    // overflow
    send_one(8'h99, 8'h00, n);
    chk("R3 overflow pulse", overflow, 1);
    chk("R3 rx head kept", rx_data, 8'hC1);
    exp_rx = '{8'hC1, 8'hFF, 8'hFF, 8'hFF};
    for (int k = 0; k < 4; k++) begin
      chk("R3 rx contents kept", rx_data, exp_rx[k]);
      pop_rx;
    end
    chk("R3 rx drained", rx_empty, 1);
    pop_rx;
    send_one(8'h3C, 8'h96, n);
    chk("R4 pop on empty ignored", rx_data, 8'h96);
    pop_rx;

    // mid-frame disable
    tx_data = 8'hF0; tx_push = 1'b1;
    @(negedge clk);
    tx_push = 1'b0;
    repeat (7) @(negedge clk);
    chk("R8 busy before disable", busy, 1);
    en = 1'b0;
    @(negedge clk);
    chk("R8 abandon frame", {busy, sclk, ss_n}, {2'b01, 8'hFF});
    en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 no restart", {busy, tx_empty, rx_empty}, 3'b011);

    // hold instance, mode 0
    ss_en_h = 8'h81;
    @(negedge clk);
    chk("R6 hold selects with empty fifo", ss_n_h, 8'h7E);
    chk("R9 mode 0 idle level", sclk_h, 0);
    h_tx = 8'h6B; miso_h = h_tx[7]; h_idx = 6;
    tx_data = 8'hD2; tx_push_h = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; tx_push_h = 1'b0; end while (!done_h && n < 5000);
    chk("R2 mode 0 duration", n, 18);
    chk("R9 mode 0 rx byte", rx_data_h, 8'h6B);
    chk("R9 mode 0 mosi byte", h_cap, 8'hD2);
    chk("R7 underrun in hold", underrun_h, 1);
    chk("R6 select held after drain", ss_n_h, 8'h7E);
    rx_pop_h = 1'b1;
    @(negedge clk);
    rx_pop_h = 1'b0;
    chk("R7 underrun single cycle", underrun_h, 0);
    ss_en_h = 8'h00;
    @(negedge clk);
    chk("R6 select follows enable", ss_n_h, 8'hFF);
    h_tx = 8'h00; miso_h = 1'b0; h_idx = 6;
    tx_data = 8'h01; tx_push_h = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; tx_push_h = 1'b0; end while (!done_h && n < 5000);
    chk("R7 no underrun with no select", underrun_h, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule